// File: doc/BRIEF.md
# Asynchronous Serial Communication Interface

This block is a full-duplex asynchronous serial port that a processor reaches through a small register window. The processor side has a chip select, one register-select line, single-cycle read and write strobes, and an 8-bit bidirectional data bus. On a write, the register-select line picks either the transmit holding register or the control register. On a read, the same line picks either the receive holding register or the status register. When chip select is low, the block leaves the data bus released.

Characters written for transmission wait in a holding register. From there they move into a shift register, which sends them with a low start bit, eight data bits (least significant bit first), an optional parity bit and one or two high stop bits. The line rests high between characters.

The receive side has its own two-flop synchronizer, its own bit timing and its own shift register. It realigns on each falling start edge and samples at 16 ticks per bit. It drops a start bit that has gone high again by its middle. It checks parity and the first stop bit, and it passes each finished character to a receive holding register that carries its own error flags. Both directions share only the oversampling tick, so they can run at the same time.

Top module: `async_serial_port`

## Requirements
- R1: While `cs` is low, the block does not drive `bus_d`, and writes have no effect on the transmit holding register or on the control register.
- R2: A write with `cs`=1 and `rs`=0 loads the transmit holding register and clears status bit 0 (transmit holding register empty). The character is then transmitted on `ser_out`.
- R3: A read with `cs`=1 and `rs`=0 returns the receive holding register. The same read clears status bits 1 to 4.
- R4: A write with `cs`=1 and `rs`=1 sets the control register: bit 0 enables parity, bit 1 selects odd parity (0 selects even), and bit 2 selects two stop bits. A read with `cs`=1 and `rs`=1 returns the status register: bit 0 is transmit holding empty, bit 1 is receive data ready, bit 2 is parity error, bit 3 is framing error, bit 4 is overrun, and bits 7 to 5 read as zero. The status value after reset is 0x01.
- R5: `ser_out` is high when idle. Each character starts with one low start bit, followed by the 8 data bits least significant bit first. Every bit lasts OVS×TICK_DIV clock cycles.
- R6: With parity enabled, a parity bit follows the data bits. Its value is the XOR of the data bits for even parity, and the inverse of that XOR for odd parity.
- R7: Each character ends with one high stop bit, or with two when control bit 2 is set. The format is taken when a character enters the shifter.
- R8: The receiver rejects a low pulse on `ser_in` that is high again by the middle of the start bit. It reports no character for such a pulse and stays ready for the next valid frame.
- R9: A received parity bit that does not match the selected parity sets status bit 2 together with data ready.
- R10: A first stop bit sampled low sets status bit 3 together with data ready.
- R11: A character that completes while data ready is still set is discarded. It sets status bit 4, and the receive holding register keeps the earlier character.
- R12: The transmit holding register is freed as soon as its character enters the shifter. A second character written during transmission therefore follows the first with no idle bit period between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rs | input | 1 | Register select: 0 is the data registers, 1 is control (write) or status (read) |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| bus_d | inout | 8 | Bidirectional processor data bus, released unless `cs` and `rd` are both high |
| ser_out | output | 1 | Serial transmit line |
| ser_in | input | 1 | Serial receive line |

## Verification
Register reads are combinational while `rd` is high, so the bench samples `bus_d` one nanosecond after it drives the strobe on a falling edge. A write takes effect at the next rising edge. On the line, bit k of a frame is due k×64 cycles after the falling start edge. The line monitor waits for that edge and then samples 32 cycles later and every 64 cycles after that, which keeps it in the middle of each bit despite up to one tick of start jitter. A received character reaches the status register about half a bit before its frame ends, with a lag of several cycles from synchronizer and tick alignment. For that reason the bench polls the status register for data ready instead of counting exact cycles. It then compares the data and flags against the next item in its scoreboard queue.

// File: rtl/asp_pkg.sv
`timescale 1ns/1ps
// Shared types for the asynchronous serial port.
// Assumes: control fields occupy bits [2:0] of the written control byte.
package asp_pkg;

    // Frame format taken from the control register (bit 2, bit 1, bit 0).
    typedef struct packed {
        logic two_stop;
        logic odd;
        logic par_en;
    } fmt_t;

    typedef enum logic {TX_IDLE, TX_SHIFT} tx_state_e;

    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

    // Status bit positions, as seen by software.
    localparam int ST_THRE = 0;
    localparam int ST_RDY  = 1;
    localparam int ST_PERR = 2;
    localparam int ST_FERR = 3;
    localparam int ST_OVR  = 4;

endpackage

// File: rtl/asp_tick.sv
`timescale 1ns/1ps
// Oversampling tick generator: a one-cycle pulse every DIV clocks.
// Assumes: DIV >= 1; with DIV == 1 the tick is permanently high.
module asp_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            // Count clocks and emit a pulse at the end of each period.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt  <= '0;
                    tick <= 1'b0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt  <= cnt + 1'b1;
                    tick <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/asp_tx.sv
`timescale 1ns/1ps
// Transmit shifter: frames one character (start, data LSB first, optional
// parity, one or two stops) and shifts it out at OVS ticks per bit.
// Assumes: load_req stays high until load_ack; fmt is sampled at load.
module asp_tx
    import asp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  fmt_t              fmt,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_data,
    output logic              load_ack,
    output logic              busy,
    output logic              ser_out
);
    localparam int FW = DATA_W + 4;
    localparam int BW = $clog2(FW + 1);
    localparam int TW = $clog2(OVS);

    tx_state_e      state;
    logic [FW-1:0]  shreg;
    logic [BW-1:0]  nbits;
    logic [BW-1:0]  bcnt;
    logic [TW-1:0]  tcnt;
    logic [FW-1:0]  frame;
    logic           pbit;

    // Build the frame image from the holding register and the current format.
    always_comb begin
        pbit = (^load_data) ^ fmt.odd;
        if (fmt.par_en) frame = {2'b11, pbit, load_data, 1'b0};
        else            frame = {3'b111, load_data, 1'b0};
    end

    assign load_ack = (state == TX_IDLE) && load_req;
    assign busy     = (state == TX_SHIFT);
    assign ser_out  = busy ? shreg[0] : 1'b1;

    // Load a frame when idle, then shift one bit per OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            shreg <= '1;
            nbits <= '0;
            bcnt  <= '0;
            tcnt  <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (load_req) begin
                        shreg <= frame;
                        nbits <= BW'(DATA_W + 2) + BW'(fmt.par_en) + BW'(fmt.two_stop);
                        bcnt  <= '0;
                        tcnt  <= '0;
                        state <= TX_SHIFT;
                    end
                end
                default: begin
                    if (tick) begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt  <= '0;
                            shreg <= {1'b1, shreg[FW-1:1]};
                            if (bcnt == nbits - 1'b1) state <= TX_IDLE;
                            else                      bcnt  <= bcnt + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/asp_rx.sv
`timescale 1ns/1ps
// Receive shifter: synchronizes the line, detects a falling start edge,
// verifies it at mid-bit, then samples data, parity and the first stop
// bit at the middle of each bit. Pulses done with data and error flags.
// Assumes: OVS is even; the line must be seen high before a new start.
module asp_rx
    import asp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  fmt_t              fmt,
    input  logic              ser_in,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int TW  = $clog2(OVS);
    localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e       state;
    logic [1:0]      sync;
    logic            rxs;
    logic            seen_high;
    logic [TW-1:0]   tcnt;
    logic [BCW-1:0]  bcnt;
    logic            pbit;
    fmt_t            fmt_q;

    assign rxs = sync[1];

    // Two-flop synchronizer for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], ser_in};
    end

    // Frame reception state machine, advanced on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            seen_high <= 1'b0;
            tcnt      <= '0;
            bcnt      <= '0;
            pbit      <= 1'b0;
            data      <= '0;
            perr      <= 1'b0;
            ferr      <= 1'b0;
            done      <= 1'b0;
            fmt_q     <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (rxs) seen_high <= 1'b1;
                    if (tick && !rxs && seen_high) begin
                        state     <= RX_START;
                        seen_high <= 1'b0;
                        tcnt      <= '0;
                        fmt_q     <= fmt;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt == TW'(OVS / 2 - 1)) begin
                            tcnt  <= '0;
                            bcnt  <= '0;
                            state <= rxs ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt <= '0;
                            data <= {rxs, data[DATA_W-1:1]};
                            if (bcnt == BCW'(DATA_W - 1))
                                state <= fmt_q.par_en ? RX_PAR : RX_STOP;
                            else
                                bcnt <= bcnt + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_PAR: begin
                    if (tick) begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt  <= '0;
                            pbit  <= rxs;
                            state <= RX_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt  <= '0;
                            done  <= 1'b1;
                            ferr  <= !rxs;
                            perr  <= fmt_q.par_en && (pbit != ((^data) ^ fmt_q.odd));
                            state <= RX_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/async_serial_port.sv
`timescale 1ns/1ps
// Full-duplex asynchronous serial port with a four-register processor
// window decoded from rs plus the access direction. Holds one transmit
// and one receive character, the frame format and the receive flags.
// Assumes: rd and wr are one-cycle strobes and never high together.
module async_serial_port
    import asp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rs,
    input  logic              rd,
    input  logic              wr,
    inout  wire  [DATA_W-1:0] bus_d,
    output logic              ser_out,
    input  logic              ser_in
);
    logic              tick;
    logic              wr_tx, wr_ctl, rd_rx, bus_oe;
    logic [DATA_W-1:0] bus_in, rdata, status;
    fmt_t              fmt;
    logic [DATA_W-1:0] thr;
    logic              thr_empty;
    logic              load_ack, tx_busy;
    logic              rx_done, rx_perr, rx_ferr;
    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] rbr;
    logic              rx_ready, rx_perr_q, rx_ferr_q, rx_ovr;

    // Access decode: direction and rs pick one of four registers.
    assign wr_tx  = cs && wr && !rs;
    assign wr_ctl = cs && wr &&  rs;
    assign rd_rx  = cs && rd && !rs;
    assign bus_oe = cs && rd;
    assign bus_in = bus_d;
    assign bus_d  = bus_oe ? rdata : {DATA_W{1'bz}};

    // Status assembly and read multiplexer.
    always_comb begin
        status          = '0;
        status[ST_THRE] = thr_empty;
        status[ST_RDY]  = rx_ready;
        status[ST_PERR] = rx_perr_q;
        status[ST_FERR] = rx_ferr_q;
        status[ST_OVR]  = rx_ovr;
        rdata           = rs ? status : rbr;
    end

    // Control register holding the frame format.
    always_ff @(posedge clk) begin
        if (!rst_n)      fmt <= '0;
        else if (wr_ctl) fmt <= bus_in[2:0];
    end

    // Transmit holding register: a write fills it, handing it to the shifter frees it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr       <= '0;
            thr_empty <= 1'b1;
        end else if (wr_tx) begin
            thr       <= bus_in;
            thr_empty <= 1'b0;
        end else if (load_ack) begin
            thr_empty <= 1'b1;
        end
    end

    // Receive holding register and flags: load, overrun or clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbr       <= '0;
            rx_ready  <= 1'b0;
            rx_perr_q <= 1'b0;
            rx_ferr_q <= 1'b0;
            rx_ovr    <= 1'b0;
        end else if (rx_done && (!rx_ready || rd_rx)) begin
            rbr       <= rx_data;
            rx_ready  <= 1'b1;
            rx_perr_q <= rx_perr;
            rx_ferr_q <= rx_ferr;
            rx_ovr    <= 1'b0;
        end else if (rx_done) begin
            rx_ovr    <= 1'b1;
        end else if (rd_rx) begin
            rx_ready  <= 1'b0;
            rx_perr_q <= 1'b0;
            rx_ferr_q <= 1'b0;
            rx_ovr    <= 1'b0;
        end
    end

    asp_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    asp_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .fmt       (fmt),
        .load_req  (!thr_empty),
        .load_data (thr),
        .load_ack  (load_ack),
        .busy      (tx_busy),
        .ser_out   (ser_out)
    );

    asp_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .fmt    (fmt),
        .ser_in (ser_in),
        .done   (rx_done),
        .data   (rx_data),
        .perr   (rx_perr),
        .ferr   (rx_ferr)
    );
endmodule

// File: rtl/async_serial_port_chk.sv
`timescale 1ns/1ps
// Property checker for the serial port, attached by bind.
// Assumes: observes the top's decode, holding and shifter handshakes.
module async_serial_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              rs,
    input logic              rd,
    input logic              wr,
    input logic              bus_oe,
    input logic              ser_out,
    input logic              tx_busy,
    input logic              thr_empty,
    input logic              rx_done,
    input logic              rx_ready,
    input logic              rx_ovr,
    input logic [DATA_W-1:0] rbr
);
    p_bus_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !bus_oe);

    p_thr_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !rs) |=> !thr_empty);

    p_ready_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !rs && !rx_done) |=> !rx_ready);

    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> ser_out);

    p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !ser_out);

    p_overrun_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ready && !(cs && rd && !rs)) |=> (rx_ovr && $stable(rbr)));
endmodule

bind async_serial_port async_serial_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .rs        (rs),
    .rd        (rd),
    .wr        (wr),
    .bus_oe    (bus_oe),
    .ser_out   (ser_out),
    .tx_busy   (tx_busy),
    .thr_empty (thr_empty),
    .rx_done   (rx_done),
    .rx_ready  (rx_ready),
    .rx_ovr    (rx_ovr),
    .rbr       (rbr)
);

// File: tb/async_serial_port_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected frames and characters,
// a line monitor and a receive collector pop and compare them.
module async_serial_port_test;
    localparam int DW   = 8;
    localparam int OVS  = 16;
    localparam int TDIV = 4;
    localparam int BIT  = OVS * TDIV;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          t_cs = 1'b0, t_rs = 1'b0, t_rd = 1'b0, t_wr = 1'b0;
    logic          drv_en = 1'b0, loop = 1'b1, drv_line = 1'b1;
    logic [DW-1:0] drv = '0;
    wire  [DW-1:0] bus;
    wire           ser_out_w;
    wire           ser_in_w;

    assign bus      = drv_en ? drv : {DW{1'bz}};
    assign ser_in_w = loop ? ser_out_w : drv_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic pe_c = 1'b0, odd_c = 1'b0, two_c = 1'b0;

    typedef struct { logic [DW-1:0] d; logic pe; logic odd; logic two; } lf_t;
    typedef struct { logic [DW-1:0] d; logic perr; logic ferr; } rx_t;
    lf_t line_q[$];
    rx_t rx_q[$];

    async_serial_port #(.DATA_W(DW), .OVS(OVS), .TICK_DIV(TDIV)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (t_cs),
        .rs      (t_rs),
        .rd      (t_rd),
        .wr      (t_wr),
        .bus_d   (bus),
        .ser_out (ser_out_w),
        .ser_in  (ser_in_w)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic c, input logic r, input logic [DW-1:0] d);
        @(negedge clk);
        t_cs = c; t_rs = r; t_wr = 1'b1; drv_en = 1'b1; drv = d;
        @(negedge clk);
        t_cs = 1'b0; t_wr = 1'b0; drv_en = 1'b0;
    endtask

    task automatic bus_read(input logic r, output logic [DW-1:0] d);
        @(negedge clk);
        t_cs = 1'b1; t_rs = r; t_rd = 1'b1;
        #1 d = bus;
        @(negedge clk);
        t_cs = 1'b0; t_rd = 1'b0;
    endtask

    // Driver: queue the expected frame and character, then write the holding register.
    task automatic send_char(input logic [DW-1:0] d);
        logic [DW-1:0] s;
        int g;
        line_q.push_back('{d, pe_c, odd_c, two_c});
        rx_q.push_back('{d, 1'b0, 1'b0});
        g = 0;
        do begin bus_read(1'b1, s); g++; end while (!s[0] && g < 5000);
        bus_write(1'b1, 1'b0, d);
    endtask

    // Receive collector: wait for data ready, compare flags and data, confirm clearing.
    task automatic collect(input string req);
        logic [DW-1:0] s, d;
        rx_t e;
        int g;
        g = 0;
        do begin bus_read(1'b1, s); g++; end while (!s[1] && g < 5000);
        if (rx_q.size() == 0) begin
            chk({req, " unexpected character"}, 1, 0);
        end else begin
            e = rx_q.pop_front();
            chk({req, " R3 data ready"}, s[1], 1'b1);
            chk({req, " R9 parity flag"}, s[2], e.perr);
            chk({req, " R10 framing flag"}, s[3], e.ferr);
            chk({req, " R11 no overrun"}, s[4], 1'b0);
            bus_read(1'b0, d);
            chk({req, " R3 received data"}, d, e.d);
            bus_read(1'b1, s);
            chk({req, " R3 flags cleared by read"}, s[4:1], 4'h0);
        end
    endtask

    task automatic raw_bit(input logic v);
        drv_line = v;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic raw_frame(input logic [DW-1:0] d, input logic has_par, input logic pb, input logic stopv);
        raw_bit(1'b0);
        for (int i = 0; i < DW; i++) raw_bit(d[i]);
        if (has_par) raw_bit(pb);
        raw_bit(stopv);
        raw_bit(1'b1);
        raw_bit(1'b1);
    endtask

    // Line monitor: decode each frame on ser_out at mid-bit and compare.
    initial begin
        wait (rst_n === 1'b1);
        forever begin
            @(negedge ser_out_w);
            if (line_q.size() == 0) begin
                chk("R1 R5 unexpected frame on ser_out", 1, 0);
            end else begin
                lf_t e;
                e = line_q.pop_front();
                repeat (BIT / 2) @(negedge clk);
                chk("R5 start bit", ser_out_w, 1'b0);
                for (int i = 0; i < DW; i++) begin
                    repeat (BIT) @(negedge clk);
                    chk("R5 data bit LSB first", ser_out_w, e.d[i]);
                end
                if (e.pe) begin
                    repeat (BIT) @(negedge clk);
                    chk("R6 parity bit", ser_out_w, (^e.d) ^ e.odd);
                end
                repeat (BIT) @(negedge clk);
                chk("R7 first stop bit", ser_out_w, 1'b1);
                if (e.two) begin
                    repeat (BIT) @(negedge clk);
                    chk("R7 second stop bit", ser_out_w, 1'b1);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] s, d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        bus_read(1'b1, s);
        chk("R4 status after reset", s, 8'h01);
        chk("R5 line idle after reset", ser_out_w, 1'b1);

        // R1: deselected read leaves the bus to the bench; deselected writes do nothing.
        @(negedge clk);
        t_rd = 1'b1; drv_en = 1'b1; drv = 8'h5A;
        #1 chk("R1 bus released while deselected", bus, 8'h5A);
        @(negedge clk);
        t_rd = 1'b0; drv_en = 1'b0;
        bus_write(1'b0, 1'b0, 8'h77);
        bus_write(1'b0, 1'b1, 8'h07);
        repeat (2 * BIT) @(negedge clk);
        chk("R1 deselected write leaves line idle", ser_out_w, 1'b1);
        bus_read(1'b1, s);
        chk("R1 deselected write leaves holding empty", s, 8'h01);
        // Control must still be 8N1: the monitor expects that format.
        send_char(8'hC4);
        collect("R1 format unchanged");
        repeat (3 * BIT) @(negedge clk);

        // Loopback through every format, two back-to-back characters each.
        for (int f = 0; f < 6; f++) begin
            logic [DW-1:0] c1, c2;
            pe_c  = (f >= 2);
            odd_c = (f >= 4);
            two_c = f[0];
            bus_write(1'b1, 1'b1, {5'b0, two_c, odd_c, pe_c});
            c1 = (f == 1) ? 8'h00 : 8'(8'h5A + f * 37);
            c2 = (f == 1) ? 8'hFF : ~8'(8'h13 + f * 71);
            send_char(c1);
            send_char(c2);
            if (f == 0) begin
                bus_read(1'b1, s);
                chk("R12 R2 second character waits in holding register", s[0], 1'b0);
            end
            collect("R2 R4 R6 R7 R12 loopback first");
            collect("R2 R4 R6 R7 R12 loopback second");
            repeat (3 * BIT) @(negedge clk);
        end

        // Direct line stimulus for receiver corner cases.
        loop = 1'b0;
        drv_line = 1'b1;
        repeat (2 * BIT) @(negedge clk);

        // R9: even parity selected, wrong parity bit sent (0x96 has four ones).
        bus_write(1'b1, 1'b1, 8'h01);
        rx_q.push_back('{8'h96, 1'b1, 1'b0});
        raw_frame(8'h96, 1'b1, 1'b1, 1'b1);
        collect("R9 parity mismatch");

        // R10: 8N1 with the stop bit held low.
        bus_write(1'b1, 1'b1, 8'h00);
        rx_q.push_back('{8'h41, 1'b0, 1'b1});
        raw_frame(8'h41, 1'b0, 1'b0, 1'b0);
        collect("R10 stop bit low");

        // R8: short low glitch is rejected, a following frame is received.
        drv_line = 1'b0;
        repeat (8) @(negedge clk);
        drv_line = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        bus_read(1'b1, s);
        chk("R8 glitch not taken as a start bit", s, 8'h01);
        rx_q.push_back('{8'hE7, 1'b0, 1'b0});
        raw_frame(8'hE7, 1'b0, 1'b0, 1'b1);
        collect("R8 receiver recovers after glitch");

        // R11: two characters without an intervening read.
        raw_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        raw_frame(8'hC3, 1'b0, 1'b0, 1'b1);
        bus_read(1'b1, s);
        chk("R11 overrun with ready set", s, 8'h13);
        bus_read(1'b0, d);
        chk("R11 first character kept", d, 8'h3C);
        bus_read(1'b1, s);
        chk("R11 R3 overrun cleared by read", s, 8'h01);

        repeat (2 * BIT) @(negedge clk);
        chk("R5 every queued frame seen on the line", line_q.size(), 0);
        chk("R3 every queued character received", rx_q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule